// File: doc/BRIEF.md
# Interrupt and DMA Request Logic

This block collects event flags for a serial bus controller and turns them into request lines. A 16-bit status register latches one-cycle set pulses arriving from the data path. An enable register selects which of those flags may raise the single level-sensitive interrupt. A small buffer-configuration register holds two DMA enables, one per direction. Each DMA request line follows the raw ready flag of its direction while that direction's DMA enable is on, and takes no account of the interrupt enable.

Software reaches the block through a simple register port: a 2-bit select, a write strobe, a read strobe, write data and combinational read data. Status bits are cleared by writing ones, but only within a clear mask. The ready flags are cleared by the data path alone. A vector read returns the one-based position of the lowest pending enabled flag and drops that flag in the same access. All request outputs are registered, so each one changes one clock after the state that drives it.

Top module: `evt_irq_ctrl`

## Requirements
- R1: `irq_o` is high exactly when status AND enable is nonzero, taken from the state of the previous cycle (one register stage).
- R2: `rx_req_o` equals status bit 3 (receive ready) AND buffer-config bit 15 (receive DMA on). `tx_req_o` equals status bit 4 (transmit ready) AND buffer-config bit 7 (transmit DMA on). Both come from the previous cycle's state.
- R3: A buffer-config write (select 3) stores only bits 15 and 7. Bit 15 set in the written data clears enable bit 3, and bit 7 set clears enable bit 4.
- R4: A status write (select 1) clears each stored bit whose written bit is one and which lies inside mask 0x63E7. Bits 3, 4, 10, 11 and 15 are not changed by such a write.
- R5: A read with select 2 returns the one-based index of the lowest set bit of status AND enable, or 0 if there is none, and clears that status bit. A write with select 2 has no effect.
- R6: An enable write (select 0) stores the written data ANDed with 0x63FF. A read with select 0 returns the stored value.
- R7: A status read shows the `bus_busy_i` input at bit 12. Bit 12 is never stored, and a set pulse on bit 12 is ignored.
- R8: A status read returns the stored value as it was before the access. If bit 4 or bit 14 is set, the read sets bit 10 (transmit underflow).
- R9: A set pulse wins over a clear in the same cycle, whether the clear comes from a status write or from a vector read.
- R10: Reset clears status, enable and buffer-config, and drives all three request outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_pulse_i | input | 16 | One-cycle status set pulses from the data path |
| bus_busy_i | input | 1 | Bus-busy level, shown at status bit 12 on reads |
| reg_sel_i | input | 2 | Register select: 0 enable, 1 status, 2 vector, 3 buffer-config |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe (drives read side effects) |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Combinational read data for the selected register |
| irq_o | output | 1 | Level interrupt, registered |
| rx_req_o | output | 1 | Receive DMA request, registered |
| tx_req_o | output | 1 | Transmit DMA request, registered |

## Verification
The assertions check on every cycle that:
- the interrupt and the two DMA requests track their registered sources (R1, R2);
- a software clear never touches bits outside the clear mask (R4);
- a set pulse always survives a same-cycle clear (R9);
- turning on a DMA enable removes the matching interrupt enable (R3);
- the vector selection is one-hot (R5);
- the busy input appears on status reads (R7);
- a status read with transmit ready or drain pending raises underflow (R8).

Other properties rest on the bench's sweeps, which run every flag position under both DMA settings and every single-bit enable pattern. These cover:
- the exact vector values, including the zero return and the one-based encoding;
- the masked enable readback (R6);
- the replacement of buffer-config on each write;
- the fact that a status read returns the stored value from before its own side effect;
- the reset values (R10).

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

   typedef enum logic [1:0] {
      SEL_ENABLE = 2'd0,
      SEL_STATUS = 2'd1,
      SEL_VECTOR = 2'd2,
      SEL_BUFCFG = 2'd3
   } reg_sel_e;

endpackage

// File: rtl/evt_lowbit_pick.sv
module evt_lowbit_pick #(
   parameter int W     = 16,
   parameter int IDX_W = $clog2(W + 1)
) (
   input  logic [W-1:0]     vec_i,
   output logic [W-1:0]     oh_o,
   output logic [IDX_W-1:0] idx_o,
   output logic             any_o
);

   logic [W:0] seen;
   assign seen[0] = 1'b0;

   for (genvar g = 0; g < W; g++) begin : g_chain
      assign oh_o[g]     = vec_i[g] & ~seen[g];
      assign seen[g + 1] = seen[g] | vec_i[g];
   end

   assign any_o = seen[W];

   always_comb begin
      idx_o = '0;
      for (int i = 0; i < W; i++) begin
         if (oh_o[i]) idx_o = idx_o | IDX_W'(i + 1);
      end
   end

endmodule

// File: rtl/evt_status_reg.sv
module evt_status_reg #(
   parameter int           W         = 16,
   parameter logic [W-1:0] CLR_MASK  = 16'h63E7,
   parameter int           BUSY_BIT  = 12,
   parameter int           UDF_BIT   = 10,
   parameter int           TXRDY_BIT = 4,
   parameter int           DRAIN_BIT = 14
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_in,
   input  logic         clr_wr_en,
   input  logic [W-1:0] clr_data,
   input  logic         vec_clr_en,
   input  logic [W-1:0] vec_clr_oh,
   input  logic         stat_rd_en,
   output logic [W-1:0] stat_q
);

   localparam logic [W-1:0] KEEP_MASK = ~(W'(1) << BUSY_BIT);

   logic [W-1:0] stat_d;

   always_comb begin
      stat_d = stat_q;
      if (clr_wr_en)  stat_d = stat_d & ~(clr_data & CLR_MASK);
      if (vec_clr_en) stat_d = stat_d & ~vec_clr_oh;
      if (stat_rd_en && (stat_q[TXRDY_BIT] || stat_q[DRAIN_BIT]))
         stat_d[UDF_BIT] = 1'b1;
      stat_d = (stat_d | set_in) & KEEP_MASK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= stat_d;
   end

   // R4: a software clear leaves bits outside the clear mask untouched
   assert_swclr_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr_en && !vec_clr_en) |=> ((($past(stat_q) & ~CLR_MASK) & ~stat_q) == '0));

   // R9: a set pulse is present in the next state whatever else happened
   assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_in) |=> (($past(set_in) & KEEP_MASK & ~stat_q) == '0));

   // R5: the popped source is gone unless it was set again in the same cycle
   assert_vec_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_clr_en && !stat_rd_en && |(vec_clr_oh & ~set_in))
      |=> (($past(vec_clr_oh & ~set_in) & stat_q) == '0));

   // R8: a status read with transmit ready or drain pending raises underflow
   assert_udf_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd_en && (stat_q[TXRDY_BIT] || stat_q[DRAIN_BIT])) |=> stat_q[UDF_BIT]);

endmodule

// File: rtl/evt_mask_reg.sv
module evt_mask_reg #(
   parameter int           W          = 16,
   parameter logic [W-1:0] EN_MASK    = 16'h63FF,
   parameter logic [W-1:0] CFG_MASK   = 16'h8080,
   parameter int           RX_DMA_BIT = 15,
   parameter int           TX_DMA_BIT = 7,
   parameter int           RX_RDY_BIT = 3,
   parameter int           TX_RDY_BIT = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en_wr,
   input  logic         cfg_wr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] en_q,
   output logic [W-1:0] cfg_q
);

   logic [W-1:0] en_d;

   always_comb begin
      en_d = en_q;
      if (en_wr) en_d = wdata & EN_MASK;
      if (cfg_wr) begin
         if (wdata[RX_DMA_BIT]) en_d[RX_RDY_BIT] = 1'b0;
         if (wdata[TX_DMA_BIT]) en_d[TX_RDY_BIT] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         cfg_q <= '0;
      end else begin
         en_q <= en_d;
         if (cfg_wr) cfg_q <= wdata & CFG_MASK;
      end
   end

   // R3: turning on receive DMA removes the receive-ready interrupt enable
   assert_rx_dma_clears_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && !en_wr && wdata[RX_DMA_BIT]) |=> !en_q[RX_RDY_BIT]);

   // R3: turning on transmit DMA removes the transmit-ready interrupt enable
   assert_tx_dma_clears_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && !en_wr && wdata[TX_DMA_BIT]) |=> !en_q[TX_RDY_BIT]);

endmodule

// File: rtl/evt_req_out.sv
module evt_req_out #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] cond_i,
   output logic [N-1:0] req_o
);

   for (genvar g = 0; g < N; g++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) req_o[g] <= 1'b0;
         else        req_o[g] <= cond_i[g];
      end
   end

endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
   import evt_irq_pkg::*;
#(
   parameter int           W          = 16,
   parameter logic [W-1:0] CLR_MASK   = 16'h63E7,
   parameter logic [W-1:0] EN_MASK    = 16'h63FF,
   parameter logic [W-1:0] CFG_MASK   = 16'h8080,
   parameter int           RX_RDY_BIT = 3,
   parameter int           TX_RDY_BIT = 4,
   parameter int           UDF_BIT    = 10,
   parameter int           BUSY_BIT   = 12,
   parameter int           DRAIN_BIT  = 14,
   parameter int           RX_DMA_BIT = 15,
   parameter int           TX_DMA_BIT = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_pulse_i,
   input  logic         bus_busy_i,
   input  logic [1:0]   reg_sel_i,
   input  logic         wr_en_i,
   input  logic         rd_en_i,
   input  logic [W-1:0] wr_data_i,
   output logic [W-1:0] rd_data_o,
   output logic         irq_o,
   output logic         rx_req_o,
   output logic         tx_req_o
);

   localparam int IDX_W  = $clog2(W + 1);
   localparam int N_REQ  = 3;

   initial begin
      assert (IDX_W <= W) else $error("vector index does not fit the data width");
      assert (RX_RDY_BIT < W && TX_RDY_BIT < W && UDF_BIT < W) else $error("flag bit out of range");
      assert (BUSY_BIT < W && DRAIN_BIT < W) else $error("flag bit out of range");
      assert (RX_DMA_BIT < W && TX_DMA_BIT < W) else $error("DMA enable bit out of range");
   end

   reg_sel_e           sel;
   logic [W-1:0]       stat_q, en_q, cfg_q, pend, pick_oh;
   logic [IDX_W-1:0]   pick_idx;
   logic               pick_any;
   logic               stat_rd, vec_rd;
   logic [N_REQ-1:0]   req_cond, req_q;

   assign sel     = reg_sel_e'(reg_sel_i);
   assign stat_rd = rd_en_i && (sel == SEL_STATUS);
   assign vec_rd  = rd_en_i && (sel == SEL_VECTOR);
   assign pend    = stat_q & en_q;

   evt_lowbit_pick #(.W(W), .IDX_W(IDX_W)) pick_i (
      .vec_i (pend),
      .oh_o  (pick_oh),
      .idx_o (pick_idx),
      .any_o (pick_any)
   );

   evt_status_reg #(
      .W(W), .CLR_MASK(CLR_MASK), .BUSY_BIT(BUSY_BIT), .UDF_BIT(UDF_BIT),
      .TXRDY_BIT(TX_RDY_BIT), .DRAIN_BIT(DRAIN_BIT)
   ) status_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_in     (set_pulse_i),
      .clr_wr_en  (wr_en_i && (sel == SEL_STATUS)),
      .clr_data   (wr_data_i),
      .vec_clr_en (vec_rd && pick_any),
      .vec_clr_oh (pick_oh),
      .stat_rd_en (stat_rd),
      .stat_q     (stat_q)
   );

   evt_mask_reg #(
      .W(W), .EN_MASK(EN_MASK), .CFG_MASK(CFG_MASK), .RX_DMA_BIT(RX_DMA_BIT),
      .TX_DMA_BIT(TX_DMA_BIT), .RX_RDY_BIT(RX_RDY_BIT), .TX_RDY_BIT(TX_RDY_BIT)
   ) mask_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_wr  (wr_en_i && (sel == SEL_ENABLE)),
      .cfg_wr (wr_en_i && (sel == SEL_BUFCFG)),
      .wdata  (wr_data_i),
      .en_q   (en_q),
      .cfg_q  (cfg_q)
   );

   assign req_cond = {stat_q[TX_RDY_BIT] & cfg_q[TX_DMA_BIT],
                      stat_q[RX_RDY_BIT] & cfg_q[RX_DMA_BIT],
                      |pend};

   evt_req_out #(.N(N_REQ)) req_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .cond_i (req_cond),
      .req_o  (req_q)
   );

   assign irq_o    = req_q[0];
   assign rx_req_o = req_q[1];
   assign tx_req_o = req_q[2];

   always_comb begin
      rd_data_o = '0;
      case (sel)
         SEL_ENABLE: rd_data_o = en_q;
         SEL_STATUS: begin
            rd_data_o           = stat_q;
            rd_data_o[BUSY_BIT] = bus_busy_i;
         end
         SEL_VECTOR: rd_data_o = W'(pick_idx);
         SEL_BUFCFG: rd_data_o = cfg_q;
         default:    rd_data_o = '0;
      endcase
   end

   // R1: interrupt line follows pending-and-enabled one cycle later
   assert_irq_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_o == $past(|(stat_q & en_q))));

   // R2: request lines follow ready flags gated by DMA enables one cycle later
   assert_rx_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (rx_req_o == $past(stat_q[RX_RDY_BIT] & cfg_q[RX_DMA_BIT])));
   assert_tx_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (tx_req_o == $past(stat_q[TX_RDY_BIT] & cfg_q[TX_DMA_BIT])));

   // R5: at most one source is selected for popping
   assert_pick_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pick_oh));

   // R7: busy input is reflected at its bit on status reads
   assert_busy_visible_R7: assert property (@(posedge clk) disable iff (!rst_n)
      stat_rd |-> (rd_data_o[BUSY_BIT] == bus_busy_i));

endmodule

// File: tb/evt_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module evt_irq_ctrl_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] set_pulse = '0;
   logic        bus_busy = 1'b0;
   logic [1:0]  reg_sel = '0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic        irq, rx_req, tx_req;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [15:0] m_stat, m_en, m_cfg;

   always #2.5 clk = ~clk;

   evt_irq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .set_pulse_i(set_pulse), .bus_busy_i(bus_busy),
      .reg_sel_i(reg_sel), .wr_en_i(wr_en), .rd_en_i(rd_en), .wr_data_i(wr_data),
      .rd_data_o(rd_data), .irq_o(irq), .rx_req_o(rx_req), .tx_req_o(tx_req)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] low_idx(input logic [15:0] v);
      for (int i = 0; i < 16; i++) if (v[i]) return 16'(i + 1);
      return 16'd0;
   endfunction

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; tick(); tick();
      chk("R10 irq in reset", {15'd0, irq}, 16'd0);
      chk("R10 req in reset", {14'd0, rx_req, tx_req}, 16'd0);
      rst_n = 1'b1; tick();
      m_stat = '0; m_en = '0; m_cfg = '0;
   endtask

   task automatic wr(input logic [1:0] s, input logic [15:0] d);
      reg_sel = s; wr_data = d; wr_en = 1'b1; tick(); wr_en = 1'b0;
      case (s)
         2'd0: m_en = d & 16'h63FF;
         2'd1: m_stat = m_stat & ~(d & 16'h63E7);
         2'd3: begin
            m_cfg = d & 16'h8080;
            if (d[15]) m_en[3] = 1'b0;
            if (d[7])  m_en[4] = 1'b0;
         end
         default: ;
      endcase
   endtask

   task automatic rd(input logic [1:0] s, input string req);
      logic [15:0] exp;
      reg_sel = s; rd_en = 1'b1; #1;
      case (s)
         2'd0: exp = m_en;
         2'd1: exp = m_stat | (bus_busy ? 16'h1000 : 16'h0000);
         2'd2: exp = low_idx(m_stat & m_en);
         default: exp = m_cfg;
      endcase
      chk(req, rd_data, exp);
      tick(); rd_en = 1'b0;
      if (s == 2'd1 && (m_stat[4] || m_stat[14])) m_stat[10] = 1'b1;
      if (s == 2'd2 && exp != 0) m_stat[exp - 1] = 1'b0;
   endtask

   task automatic pulse(input logic [15:0] d);
      set_pulse = d; tick(); set_pulse = '0;
      m_stat = m_stat | (d & ~16'h1000);
   endtask

   task automatic check_out(input string req);
      tick();
      chk({req, " irq"}, {15'd0, irq}, {15'd0, |(m_stat & m_en)});
      chk({req, " rx_req"}, {15'd0, rx_req}, {15'd0, m_stat[3] & m_cfg[15]});
      chk({req, " tx_req"}, {15'd0, tx_req}, {15'd0, m_stat[4] & m_cfg[7]});
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R10: all registers read zero after reset
      rd(2'd0, "R10 enable"); rd(2'd1, "R10 status");
      rd(2'd2, "R10 vector"); rd(2'd3, "R10 bufcfg");
      check_out("R10");

      // R6: enable masking
      wr(2'd0, 16'hFFFF); rd(2'd0, "R6 enable all");
      wr(2'd0, 16'h9C00); rd(2'd0, "R6 enable upper");
      wr(2'd0, 16'h1234); rd(2'd0, "R6 enable pattern");

      // R8: status read returns old value and then raises underflow
      do_reset();
      pulse(16'h4000); rd(2'd1, "R8 drain first read"); rd(2'd1, "R8 drain second read");
      do_reset();
      pulse(16'h0010); rd(2'd1, "R8 txrdy first read"); rd(2'd1, "R8 txrdy second read");
      do_reset();
      pulse(16'h0001); rd(2'd1, "R8 no side effect"); rd(2'd1, "R8 no side effect again");

      // R7: busy shown but not stored; bit 12 pulses ignored
      do_reset();
      bus_busy = 1'b1; rd(2'd1, "R7 busy shown");
      bus_busy = 1'b0; pulse(16'h1000); rd(2'd1, "R7 busy not stored");
      check_out("R7");

      // R1 R2 R4 R5: sweep every flag with and without DMA enables
      for (int pass = 0; pass < 2; pass++) begin
         do_reset();
         wr(2'd0, 16'hFFFF);
         if (pass == 1) wr(2'd3, 16'hFFFF);
         rd(2'd3, "R3 bufcfg stored");
         rd(2'd0, "R3 enable after dma");
         for (int i = 0; i < 16; i++) begin
            pulse(16'(1 << i));
            check_out("R1 R2 sweep");
            rd(2'd1, "R4 status after pulse");
            rd(2'd2, "R5 vector pop");
            wr(2'd1, 16'hFFFF);
            rd(2'd1, "R4 status after clear");
            check_out("R1 R2 after clear");
         end
      end

      // R5: vector over each single-bit enable with all flags set
      for (int j = 0; j < 16; j++) begin
         do_reset();
         pulse(16'hFFFF);
         wr(2'd0, 16'(1 << j));
         check_out("R1 single enable");
         rd(2'd2, "R5 single enable vector");
         rd(2'd2, "R5 second vector");
         rd(2'd1, "R5 status after pop");
      end
      do_reset();
      wr(2'd0, 16'h63FF);
      rd(2'd2, "R5 none pending");
      wr(2'd2, 16'hFFFF); rd(2'd1, "R5 vector write ignored");

      // R3: DMA enables clear interrupt enables, bufcfg replaced each write
      do_reset();
      wr(2'd0, 16'hFFFF);
      wr(2'd3, 16'h8000); rd(2'd0, "R3 rx dma clears en3"); rd(2'd3, "R3 cfg rx");
      wr(2'd3, 16'h0080); rd(2'd0, "R3 tx dma clears en4"); rd(2'd3, "R3 cfg tx");
      pulse(16'h0018); check_out("R2 tx only");
      wr(2'd3, 16'h8000); check_out("R2 rx only");

      // R9: set wins over same-cycle software clear and vector pop
      do_reset();
      wr(2'd0, 16'hFFFF);
      pulse(16'h0021);
      set_pulse = 16'h0001; reg_sel = 2'd1; wr_data = 16'hFFFF; wr_en = 1'b1;
      tick(); wr_en = 1'b0; set_pulse = '0;
      m_stat = (m_stat & ~(16'hFFFF & 16'h63E7)) | 16'h0001;
      rd(2'd1, "R9 set over write clear");
      set_pulse = 16'h0001; reg_sel = 2'd2; rd_en = 1'b1; #1;
      chk("R9 vector value", rd_data, 16'd1);
      tick(); rd_en = 1'b0; set_pulse = '0;
      rd(2'd1, "R9 set over vector pop");
      check_out("R9");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule